// File: doc/BRIEF.md
# Extended Parallel-Port Control Window

This block is the second eight-byte register window of a parallel port. It holds an extended control byte that selects one of eight operating modes and reports the state of a small byte FIFO. It also holds a general-purpose configuration byte, a plain data byte, and a read-only capability byte that reports the FIFO's data width. Software reaches all of it through a one-byte register bus with a 3-bit offset.

Only the FIFO-test mode moves data. In that mode a write to offset 0 pushes a byte into the FIFO and a read from offset 0 pops one. In every mode except FIFO test and configuration, offset 0 is an ordinary storage byte. Any write to the extended control byte that changes the mode empties the FIFO. The other modes only select register behaviour here; nothing in this block drives pins.

Read data is combinational from the current state. The side effects of a read or write (a pop, a push, a register load) take place at the next rising clock edge. The bus issues at most one access per cycle.

Top module: `ecp_ext_regs`

## Requirements
- R1: After reset, the extended control byte (offset 2) reads 0x01: mode 000, bits 4:2 zero, FIFO status 01 = empty. The configuration byte (offset 1) reads 0x00, and offset 0 in mode 000 reads 0x00.
- R2: A write to offset 2 loads bits 7:5 as the mode and bits 4:2 as stored bits. Bits 1:0 ignore the written value and always read the FIFO status code.
- R3: A write to offset 2 whose mode differs from the current mode empties the FIFO, so the status reads 01 and a later pop sees no old data. A write that repeats the current mode keeps the FIFO contents.
- R4: In mode 110 (FIFO test), a write to offset 0 pushes a byte and a read from offset 0 returns the oldest byte and pops it. The status code is 00 while partly filled and 10 when the fill level equals the depth (default 2).
- R5: A push while the FIFO is full is discarded. A pop while it is empty returns 0xFF. Neither changes the stored contents or the status.
- R6: The FIFO pointers wrap to zero after the last entry, so first-in first-out order holds across any number of push/pop sequences.
- R7: In modes 000 to 101, offset 0 is a read/write byte register and its accesses leave the FIFO untouched.
- R8: In mode 111 (configuration), offset 0 reads the capability byte: bits 6:4 give the FIFO width code (001 = 8-bit, 000 = 16-bit, 010 = 32-bit) and all other bits are 0, so the default reads 0x10. Writes to offset 0 in this mode are discarded.
- R9: Offset 1 is a read/write configuration byte that changes only when it is written.
- R10: Offsets 3 to 7 read 0xFF and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register offset within the window |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data byte |
| bus_rd | input | 1 | Read strobe for one cycle (pops in FIFO-test mode) |
| bus_rdata | output | 8 | Read data, combinational from current state |

## Verification
Read data is due in the same cycle as the read strobe, so the bench drives the address and strobe just after a falling edge and samples `bus_rdata` a short settle time later, before the rising edge. Every write, push, pop and flush takes effect at that rising edge and is visible from the next cycle on. The bench therefore updates its reference model after the edge and checks each effect through a later read. Status bits and FIFO order are checked this way after every mode change, overflow and underflow.

// File: rtl/ecp_ext_pkg.sv
package ecp_ext_pkg;

  typedef enum logic [2:0] {
    MODE_COMPAT  = 3'b000,
    MODE_BYTE    = 3'b001,
    MODE_PPFIFO  = 3'b010,
    MODE_ECPFIFO = 3'b011,
    MODE_EPP     = 3'b100,
    MODE_RSVD    = 3'b101,
    MODE_FTEST   = 3'b110,
    MODE_CONFIG  = 3'b111
  } ecp_mode_e;

  localparam logic [1:0] FST_PART  = 2'b00;
  localparam logic [1:0] FST_EMPTY = 2'b01;
  localparam logic [1:0] FST_FULL  = 2'b10;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_CFGB = 3'd1;
  localparam logic [2:0] OFS_ECR  = 3'd2;

  // Two-bit fill code from an occupancy count.
  function automatic logic [1:0] fifo_status(input int unsigned fill,
                                             input int unsigned depth);
    if (fill == 0)          return FST_EMPTY;
    else if (fill >= depth) return FST_FULL;
    else                    return FST_PART;
  endfunction

  // Width code reported in the capability byte.
  function automatic logic [2:0] width_code(input int unsigned bits);
    case (bits)
      16:      return 3'b000;
      32:      return 3'b010;
      default: return 3'b001;
    endcase
  endfunction

  function automatic logic [7:0] cfga_byte(input logic [2:0] wc);
    return {1'b0, wc, 4'b0000};
  endfunction

endpackage

// File: rtl/ecp_ext_fifo.sv
module ecp_ext_fifo #(
  parameter int DEPTH = 2,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          empty, full, push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (32'(cnt) == DEPTH);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign count = cnt;

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= DEPTH);

  // R5
  full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(cnt) && $stable(wr_ptr));

  // R5
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> (cnt == '0) && $stable(rd_ptr));

endmodule

// File: rtl/ecp_ext_ctrl.sv
module ecp_ext_ctrl
  import ecp_ext_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_ecr,
  input  logic      wr_cfgb,
  input  logic      wr_plain,
  input  logic [7:0] wdata,
  output ecp_mode_e mode,
  output logic [2:0] ecr_aux,
  output logic [7:0] cfgb,
  output logic [7:0] plain,
  output logic      mode_change
);

  assign mode_change = wr_ecr && (wdata[7:5] != 3'(mode));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_COMPAT;
      ecr_aux <= '0;
      cfgb    <= '0;
      plain   <= '0;
    end else begin
      if (wr_ecr) begin
        mode    <= ecp_mode_e'(wdata[7:5]);
        ecr_aux <= wdata[4:2];
      end
      if (wr_cfgb)  cfgb  <= wdata;
      if (wr_plain) plain <= wdata;
    end
  end

  // R2
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ecr |=> (3'(mode) == $past(wdata[7:5])));

  // R9
  cfgb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfgb |=> $stable(cfgb));

endmodule

// File: rtl/ecp_ext_regs.sv
module ecp_ext_regs
  import ecp_ext_pkg::*;
#(
  parameter int FIFO_DEPTH      = 2,
  parameter int FIFO_WIDTH_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata
);

  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [7:0] CFGA_VAL = cfga_byte(width_code(FIFO_WIDTH_BITS));

  ecp_mode_e  mode;
  logic [2:0] ecr_aux;
  logic [7:0] cfgb, plain, fifo_rdata;
  logic [CW-1:0] fifo_count;
  logic [1:0] ecr_status;
  logic       in_ftest, in_cfg, at_data;
  logic       fifo_push, fifo_pop, plain_we, mode_change, fifo_empty;

  assign in_ftest  = (mode == MODE_FTEST);
  assign in_cfg    = (mode == MODE_CONFIG);
  assign at_data   = (bus_addr == OFS_DATA);
  assign fifo_push = bus_wr && at_data && in_ftest;
  assign fifo_pop  = bus_rd && at_data && in_ftest;
  assign plain_we  = bus_wr && at_data && !in_ftest && !in_cfg;

  ecp_ext_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ecr      (bus_wr && bus_addr == OFS_ECR),
    .wr_cfgb     (bus_wr && bus_addr == OFS_CFGB),
    .wr_plain    (plain_we),
    .wdata       (bus_wdata),
    .mode        (mode),
    .ecr_aux     (ecr_aux),
    .cfgb        (cfgb),
    .plain       (plain),
    .mode_change (mode_change)
  );

  ecp_ext_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (mode_change),
    .push  (fifo_push),
    .pop   (fifo_pop),
    .wdata (bus_wdata),
    .rdata (fifo_rdata),
    .count (fifo_count)
  );

  assign ecr_status = fifo_status(32'(fifo_count), FIFO_DEPTH);
  assign fifo_empty = (fifo_count == '0);

  always_comb begin
    unique case (bus_addr)
      OFS_DATA: begin
        if (in_ftest)    bus_rdata = fifo_empty ? 8'hFF : fifo_rdata;
        else if (in_cfg) bus_rdata = CFGA_VAL;
        else             bus_rdata = plain;
      end
      OFS_CFGB: bus_rdata = cfgb;
      OFS_ECR:  bus_rdata = {mode, ecr_aux, ecr_status};
      default:  bus_rdata = 8'hFF;
    endcase
  end

  // R3
  mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_change |=> (ecr_status == FST_EMPTY));

  // R5
  empty_pop_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && fifo_empty) |-> (bus_rdata == 8'hFF));

  // R10
  reserved_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > OFS_ECR) |-> (bus_rdata == 8'hFF));

endmodule

// File: tb/test_ecp_ext_regs.sv
`timescale 1ns/1ps
module test_ecp_ext_regs;

  localparam int DEPTH = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int n_checks = 0, n_fail = 0;

  // reference model
  logic [2:0] m_mode = 3'd0, m_aux = 3'd0;
  logic [7:0] m_cfgb = 8'h00, m_plain = 8'h00;
  logic [7:0] m_q[$];

  always #10 clk = ~clk;

  ecp_ext_regs i_ecp_ext_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  function automatic logic [1:0] exp_status(int fill);
    return (fill == 0) ? 2'b01 : (fill == DEPTH) ? 2'b10 : 2'b00;
  endfunction

  function automatic logic [7:0] exp_read(logic [2:0] a);
    case (a)
      3'd0: begin
        if (m_mode == 3'd6) return (m_q.size() == 0) ? 8'hFF : m_q[0];
        if (m_mode == 3'd7) return 8'h10;
        return m_plain;
      end
      3'd1: return m_cfgb;
      3'd2: return {m_mode, m_aux, exp_status(m_q.size())};
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic bw(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    case (a)
      3'd0: begin
        if (m_mode == 3'd6) begin
          if (m_q.size() < DEPTH) m_q.push_back(d);
        end else if (m_mode != 3'd7) m_plain = d;
      end
      3'd1: m_cfgb = d;
      3'd2: begin
        if (d[7:5] != m_mode) m_q.delete();
        m_mode = d[7:5];
        m_aux  = d[4:2];
      end
      default: ;
    endcase
  endtask

  task automatic br(logic [2:0] a, string req);
    logic [7:0] e;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    e = exp_read(a);
    #2;
    check(req, bus_rdata, e);
    @(posedge clk); #1;
    bus_rd = 1'b0;
    if (a == 3'd0 && m_mode == 3'd6 && m_q.size() > 0) void'(m_q.pop_front());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    br(3'd2, "R1"); br(3'd1, "R1"); br(3'd0, "R1");
    // R9 configuration byte
    bw(3'd1, 8'hA5); br(3'd1, "R9");
    // R2 bits 1:0 ignore written value
    bw(3'd2, 8'hFF); br(3'd2, "R2");
    // R8 capability byte in mode 111, writes discarded
    br(3'd0, "R8"); bw(3'd0, 8'h55); br(3'd0, "R8");
    bw(3'd2, 8'h00); br(3'd0, "R8");
    // R7 plain byte register, FIFO untouched
    bw(3'd0, 8'h3C); br(3'd0, "R7"); br(3'd2, "R7");
    bw(3'd2, 8'h80); br(3'd0, "R7");
    // R4 FIFO test push/pop and status
    bw(3'd2, 8'hC0); bw(3'd0, 8'h11); br(3'd2, "R4");
    bw(3'd0, 8'h22); br(3'd2, "R4");
    // R5 overflow discarded
    bw(3'd0, 8'h33); br(3'd2, "R5");
    br(3'd0, "R4"); br(3'd0, "R4"); br(3'd2, "R4");
    // R5 underflow returns FF, status stays empty
    br(3'd0, "R5"); br(3'd2, "R5");
    // R3 same mode keeps data, different mode flushes
    bw(3'd0, 8'h44); bw(3'd2, 8'hC4); br(3'd2, "R3"); br(3'd0, "R3");
    bw(3'd0, 8'h55); bw(3'd2, 8'h20); br(3'd2, "R3");
    bw(3'd2, 8'hC0); br(3'd0, "R3");
    // R6 wraparound order
    for (int i = 0; i < 7; i++) begin
      bw(3'd0, 8'(8'h60 + i));
      if (i % 2 == 1) bw(3'd0, 8'(8'h90 + i));
      br(3'd0, "R6");
      if (i % 2 == 1) br(3'd0, "R6");
    end
    // R10 reserved offsets
    bw(3'd5, 8'h77); br(3'd5, "R10"); br(3'd7, "R10"); br(3'd1, "R10");

    // constrained random mix
    for (int n = 0; n < 800; n++) begin
      int r;
      r = $urandom % 16;
      if (r < 2) begin
        logic [2:0] md;
        md = ($urandom % 4 == 0) ? 3'($urandom) : 3'd6;
        bw(3'd2, {md, 5'($urandom)});
      end else if (r < 7)  bw(3'd0, 8'($urandom));
      else if (r < 12)     br(3'd0, "RND");
      else if (r == 12)    bw(3'd1, 8'($urandom));
      else if (r == 13)    br(3'd1, "RND");
      else if (r == 14)    br(3'd2, "RND");
      else begin
        logic [2:0] ra;
        ra = 3'(3 + $urandom % 5);
        bw(ra, 8'($urandom));
        br(ra, "RND");
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule